// File: doc/BRIEF.md
# DVI Scanline Symbol Sequencer

This block generates the three 10-bit symbol streams of a DVI link for one video mode. The mode is set by programmable counts. Horizontally there are four counts: front porch, sync, back porch and active width. Vertically there are four line counts of the same kinds. Two polarity bits complete the mode. Every clock cycle the block emits one 20-bit word per lane. A word holds two symbols, and the symbol in bits [9:0] goes on the wire first. All horizontal counts are therefore in units of two pixels.

Two state machines share one region-counter design and track the raster position. Both use the region states FRONT, SYNC, BACK and ACTIVE, always in that order and wrapping from ACTIVE back to FRONT. The horizontal machine advances every cycle. The vertical machine advances only at the end of a line. On a transition each machine moves to the next state whose programmed length is nonzero, and its counter restarts at zero.

A symbol mux picks one of three output modes per cycle:
- BLANK sends control symbols. Both syncs travel on lane 0 only.
- PIXEL passes through the already-encoded pixel words that the pixel source offers with a valid/ready handshake.
- FILL sends a repeating DC-balanced solid-red pair. This is used when the line has no pixel data or when the source underruns.

Just before each active region of an active line, a one-cycle strobe asks the source for that line's pixels.

Top module: `tmds_line_sequencer`

## Requirements
- R1: After reset the vertical machine is in FRONT with line count zero. It steps FRONT, SYNC, BACK, ACTIVE and wraps to FRONT. Each state lasts its programmed number of lines, and the state changes only at the end of a line.
- R2: Each line on lane 0 is the four horizontal regions in the order FRONT, SYNC, BACK, ACTIVE, each lasting its programmed number of cycles (two pixels per cycle).
- R3: Lanes 1 and 2 send the index-0 control symbol during the whole horizontal blanking (FRONT+SYNC+BACK) of every line, and during the entire line on vertical-blanking lines.
- R4: The control symbol index is {vsync level, hsync level}. The encodings are 0 = 0x354, 1 = 0x0AB, 2 = 0x154 and 3 = 0x2AB. A control word carries the same symbol in both halves.
- R5: Each sync level is its asserted flag XOR the inverse of its polarity bit. Polarity 1 drives the level high when asserted, and polarity 0 drives it low when asserted. Hsync is asserted in the horizontal SYNC region, and vsync is asserted in the vertical SYNC state.
- R6: On vertical-blanking lines, lane 0 keeps sending control symbols through the active-width region, with hsync deasserted.
- R7: On an active line with the no-pixel flag set, the active region carries fill words. Lanes 0 and 1 send word 0x7FD00 (0x100 first, then 0x1FF). Lane 2 sends word 0xBFA01 (0x201 first, then 0x2FE).
- R8: pix_ready is high only in the active region of an active line, and only when the no-pixel flag is low. Whenever pix_ready and pix_valid are both high, each lane's output word equals its pixel input word in the same cycle.
- R9: line_req is high for exactly one cycle per active line: the last cycle before the active region, which is the last cycle of the last nonzero blanking region.
- R10: A region programmed to zero length is skipped and emits no symbols, in both axes.
- R11: If pix_ready is high and pix_valid is low, that cycle carries fill words on all lanes. underrun_err goes high from the next cycle and stays high until reset.
- R12: During reset and directly after it, pix_ready, line_req and underrun_err are low. Lane 0 carries the control symbol for both syncs deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_front | input | 12 | Horizontal front porch, in words |
| h_sync | input | 12 | Horizontal sync width, in words |
| h_back | input | 12 | Horizontal back porch, in words |
| h_active | input | 12 | Horizontal active width, in words |
| v_front | input | 12 | Vertical front porch, in lines |
| v_sync | input | 12 | Vertical sync width, in lines |
| v_back | input | 12 | Vertical back porch, in lines |
| v_active | input | 12 | Vertical active height, in lines |
| h_pol | input | 1 | Hsync polarity, 1 = positive |
| v_pol | input | 1 | Vsync polarity, 1 = positive |
| pix_none | input | 1 | No pixel data for the current line |
| pix_valid | input | 1 | Pixel words on the pix_lane inputs are valid |
| pix_ready | output | 1 | Block consumes the pixel words this cycle |
| pix_lane0 | input | 20 | Encoded pixel word, lane 0 |
| pix_lane1 | input | 20 | Encoded pixel word, lane 1 |
| pix_lane2 | input | 20 | Encoded pixel word, lane 2 |
| sym_lane0 | output | 20 | Output symbol pair, lane 0 |
| sym_lane1 | output | 20 | Output symbol pair, lane 1 |
| sym_lane2 | output | 20 | Output symbol pair, lane 2 |
| line_req | output | 1 | Request pixels for the coming active region |
| underrun_err | output | 1 | Sticky pixel underrun flag |

## Verification
The symbol words, pix_ready and line_req are decoded directly from the two state registers and the current inputs. They are therefore due in the same cycle as the raster position that causes them, and a change of position takes one rising edge. Only underrun_err adds a register, so it is due one cycle after the underrun cycle.

The bench releases reset on a falling edge. It then derives the expected raster position purely from the count of rising edges since release and the programmed lengths. It changes pixel inputs on the falling edge and compares all outputs 1 ns later, which is well clear of the next rising edge.

// File: rtl/tmds_seq_pkg.sv
package tmds_seq_pkg;

    localparam int SYM_W  = 10;
    localparam int WORD_W = 2 * SYM_W;

    typedef enum logic [1:0] {
        RG_FRONT  = 2'd0,
        RG_SYNC   = 2'd1,
        RG_BACK   = 2'd2,
        RG_ACTIVE = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        OM_BLANK,
        OM_PIXEL,
        OM_FILL
    } out_mode_e;

    // DC-balanced solid-red fill pair, low half sent first
    localparam logic [SYM_W-1:0] FILL_RG_FIRST  = 10'h100;
    localparam logic [SYM_W-1:0] FILL_RG_SECOND = 10'h1FF;
    localparam logic [SYM_W-1:0] FILL_B_FIRST   = 10'h201;
    localparam logic [SYM_W-1:0] FILL_B_SECOND  = 10'h2FE;

    function automatic logic [SYM_W-1:0] ctrl_symbol(input logic [1:0] idx);
        logic [SYM_W-1:0] s;
        unique case (idx)
            2'd0: s = 10'h354;
            2'd1: s = 10'h0AB;
            2'd2: s = 10'h154;
            default: s = 10'h2AB;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmds_region_ctr.sv
module tmds_region_ctr
    import tmds_seq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [3:0][LEN_W-1:0] lens,
    output region_e               region,
    output region_e               region_next,
    output logic                  at_end
);

    localparam int NREG = 4;

    region_e          state;
    region_e          nxt;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W:0]   cnt_inc;
    logic             found;

    always_comb begin
        cur_len = lens[state];
        cnt_inc = {1'b0, cnt} + {{LEN_W{1'b0}}, 1'b1};
        at_end  = cnt_inc >= {1'b0, cur_len};
        nxt     = state;
        found   = 1'b0;
        for (int k = 1; k <= NREG; k++) begin
            logic [1:0] cand;
            cand = state + 2'(k);
            if (!found && lens[cand] != '0) begin
                nxt   = region_e'(cand);
                found = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RG_FRONT;
        end else if (step && at_end) begin
            unique case (state)
                RG_FRONT, RG_SYNC, RG_BACK, RG_ACTIVE: state <= nxt;
            endcase
        end
    end

    // position counter inside the region
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= at_end ? '0 : cnt_inc[LEN_W-1:0];
        end
    end

    assign region      = state;
    assign region_next = nxt;

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len != '0) |-> (cnt < cur_len)); // R2

    AST_NO_ZERO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_end && found) |=> (cur_len != '0)); // R10

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state)); // R1

endmodule

// File: rtl/tmds_symbol_mux.sv
module tmds_symbol_mux
    import tmds_seq_pkg::*;
(
    input  region_e             h_reg,
    input  region_e             v_reg,
    input  logic                h_pol,
    input  logic                v_pol,
    input  logic                pix_none,
    input  logic                pix_valid,
    input  logic [WORD_W-1:0]   pix0,
    input  logic [WORD_W-1:0]   pix1,
    input  logic [WORD_W-1:0]   pix2,
    output logic [WORD_W-1:0]   lane0,
    output logic [WORD_W-1:0]   lane1,
    output logic [WORD_W-1:0]   lane2,
    output logic                ready,
    output logic                underrun
);

    out_mode_e        mode;
    logic             in_active;
    logic             hs_lvl;
    logic             vs_lvl;
    logic [SYM_W-1:0] sync_sym;
    logic [SYM_W-1:0] idle_sym;

    always_comb begin
        in_active = (h_reg == RG_ACTIVE) && (v_reg == RG_ACTIVE);
        hs_lvl    = (h_reg == RG_SYNC) ^ ~h_pol;
        vs_lvl    = (v_reg == RG_SYNC) ^ ~v_pol;
        sync_sym  = ctrl_symbol({vs_lvl, hs_lvl});
        idle_sym  = ctrl_symbol(2'b00);
        ready     = in_active && !pix_none;
        underrun  = ready && !pix_valid;
        if (!in_active)
            mode = OM_BLANK;
        else if (ready && pix_valid)
            mode = OM_PIXEL;
        else
            mode = OM_FILL;
    end

    always_comb begin
        unique case (mode)
            OM_BLANK: begin
                lane0 = {sync_sym, sync_sym};
                lane1 = {idle_sym, idle_sym};
                lane2 = {idle_sym, idle_sym};
            end
            OM_PIXEL: begin
                lane0 = pix0;
                lane1 = pix1;
                lane2 = pix2;
            end
            default: begin
                lane0 = {FILL_RG_SECOND, FILL_RG_FIRST};
                lane1 = {FILL_RG_SECOND, FILL_RG_FIRST};
                lane2 = {FILL_B_SECOND, FILL_B_FIRST};
            end
        endcase
    end

endmodule

// File: rtl/tmds_line_sequencer.sv
module tmds_line_sequencer
    import tmds_seq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  h_front,
    input  logic [LEN_W-1:0]  h_sync,
    input  logic [LEN_W-1:0]  h_back,
    input  logic [LEN_W-1:0]  h_active,
    input  logic [LEN_W-1:0]  v_front,
    input  logic [LEN_W-1:0]  v_sync,
    input  logic [LEN_W-1:0]  v_back,
    input  logic [LEN_W-1:0]  v_active,
    input  logic              h_pol,
    input  logic              v_pol,
    input  logic              pix_none,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [19:0]       pix_lane0,
    input  logic [19:0]       pix_lane1,
    input  logic [19:0]       pix_lane2,
    output logic [19:0]       sym_lane0,
    output logic [19:0]       sym_lane1,
    output logic [19:0]       sym_lane2,
    output logic              line_req,
    output logic              underrun_err
);

    logic [3:0][LEN_W-1:0] h_lens;
    logic [3:0][LEN_W-1:0] v_lens;
    region_e               h_reg, h_next, v_reg, v_next;
    logic                  h_end, v_end, line_end;
    logic                  underrun_now;

    assign h_lens = {h_active, h_back, h_sync, h_front};
    assign v_lens = {v_active, v_back, v_sync, v_front};

    tmds_region_ctr #(.LEN_W(LEN_W)) u_hctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (1'b1),
        .lens        (h_lens),
        .region      (h_reg),
        .region_next (h_next),
        .at_end      (h_end)
    );

    // a line ends when the horizontal machine wraps around
    assign line_end = h_end && (h_next <= h_reg);

    tmds_region_ctr #(.LEN_W(LEN_W)) u_vctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (line_end),
        .lens        (v_lens),
        .region      (v_reg),
        .region_next (v_next),
        .at_end      (v_end)
    );

    tmds_symbol_mux u_mux (
        .h_reg     (h_reg),
        .v_reg     (v_reg),
        .h_pol     (h_pol),
        .v_pol     (v_pol),
        .pix_none  (pix_none),
        .pix_valid (pix_valid),
        .pix0      (pix_lane0),
        .pix1      (pix_lane1),
        .pix2      (pix_lane2),
        .lane0     (sym_lane0),
        .lane1     (sym_lane1),
        .lane2     (sym_lane2),
        .ready     (pix_ready),
        .underrun  (underrun_now)
    );

    always_comb begin
        line_req = (v_reg == RG_ACTIVE) && (h_reg != RG_ACTIVE) &&
                   h_end && (h_next == RG_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            underrun_err <= 1'b0;
        else if (underrun_now)
            underrun_err <= 1'b1;
    end

    AST_REQ_THEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |=> (h_reg == RG_ACTIVE && v_reg == RG_ACTIVE)); // R9

    AST_READY_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> (h_reg == RG_ACTIVE && v_reg == RG_ACTIVE)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_err |=> underrun_err); // R11

    AST_V_ONLY_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(v_reg)); // R1

    AST_V_TAKES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && v_end) |=> (v_reg == $past(v_next))); // R1

    AST_IDLE_LANE1_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (h_reg != RG_ACTIVE || v_reg != RG_ACTIVE) |-> (sym_lane1 == 20'hD5354)); // R3

endmodule

// File: tb/test_tmds_line_sequencer.sv
module test_tmds_line_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] h_front, h_sync, h_back, h_active;
    logic [11:0] v_front, v_sync, v_back, v_active;
    logic        h_pol, v_pol, pix_none, pix_valid;
    logic [19:0] pix_lane0, pix_lane1, pix_lane2;
    logic        pix_ready, line_req, underrun_err;
    logic [19:0] sym_lane0, sym_lane1, sym_lane2;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tmds_line_sequencer i_tmds_line_sequencer (
        .clk(clk), .rst_n(rst_n),
        .h_front(h_front), .h_sync(h_sync), .h_back(h_back), .h_active(h_active),
        .v_front(v_front), .v_sync(v_sync), .v_back(v_back), .v_active(v_active),
        .h_pol(h_pol), .v_pol(v_pol), .pix_none(pix_none), .pix_valid(pix_valid),
        .pix_ready(pix_ready),
        .pix_lane0(pix_lane0), .pix_lane1(pix_lane1), .pix_lane2(pix_lane2),
        .sym_lane0(sym_lane0), .sym_lane1(sym_lane1), .sym_lane2(sym_lane2),
        .line_req(line_req), .underrun_err(underrun_err)
    );

    task automatic chk(input string tag, input string what, input int k,
                       input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cycle=%0d actual=%h expected=%h", tag, what, k, act, exp);
        end
    endtask

    // R4 encodings
    function automatic logic [9:0] ctl(input int idx);
        case (idx)
            0: return 10'h354;
            1: return 10'h0AB;
            2: return 10'h154;
            default: return 10'h2AB;
        endcase
    endfunction

    function automatic int region_of(input int pos, input int a, input int b, input int c);
        if (pos < a) return 0;
        if (pos < a + b) return 1;
        if (pos < a + b + c) return 2;
        return 3;
    endfunction

    task automatic do_reset(input int hf, input int hs, input int hb, input int ha,
                            input int vf, input int vs, input int vb, input int va,
                            input logic hp, input logic vp, input logic none);
        rst_n = 1'b0;
        h_front = 12'(hf); h_sync = 12'(hs); h_back = 12'(hb); h_active = 12'(ha);
        v_front = 12'(vf); v_sync = 12'(vs); v_back = 12'(vb); v_active = 12'(va);
        h_pol = hp; v_pol = vp; pix_none = none; pix_valid = 1'b0;
        pix_lane0 = '0; pix_lane1 = '0; pix_lane2 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs frames and compares every output each cycle against a raster
    // position derived from the number of edges since reset release.
    // under_mode: pix_valid low on every third cycle.
    task automatic run_case(input int hf, input int hs, input int hb, input int ha,
                            input int vf, input int vs, input int vb, input int va,
                            input logic hp, input logic vp, input logic none,
                            input logic under_mode, input int nframes);
        int line_len = hf + hs + hb + ha;
        int frame_len = vf + vs + vb + va;
        int hblank = hf + hs + hb;
        logic err_exp = 1'b0;
        do_reset(hf, hs, hb, ha, vf, vs, vb, va, hp, vp, none);
        for (int k = 0; k < nframes * frame_len * line_len; k++) begin
            int col = k % line_len;
            int line = (k / line_len) % frame_len;
            int hr = region_of(col, hf, hs, hb);
            int vr = region_of(line, vf, vs, vb);
            logic act_cell = (hr == 3) && (vr == 3);
            logic valid_k = under_mode ? ((k % 3) != 0) : 1'b1;
            logic hlev = (hr == 1) ^ ~hp;
            logic vlev = (vr == 1) ^ ~vp;
            logic [19:0] e0, e1, e2;
            logic rdy_exp, req_exp;
            pix_valid = valid_k;
            pix_lane0 = 20'(k * 7 + 1);
            pix_lane1 = 20'(k * 13 + 5);
            pix_lane2 = 20'(k) ^ 20'hABCDE;
            #1;
            rdy_exp = act_cell && !none;
            req_exp = (vr == 3) && (hblank > 0) && (col == hblank - 1);
            if (!act_cell) begin
                e0 = {2{ctl({30'd0, vlev, hlev})}};
                e1 = {2{ctl(0)}};
                e2 = {2{ctl(0)}};
            end else if (rdy_exp && valid_k) begin
                e0 = pix_lane0; e1 = pix_lane1; e2 = pix_lane2;
            end else begin
                e0 = 20'h7FD00; e1 = 20'h7FD00; e2 = 20'hBFA01;
            end
            chk("R2 R4 R5 R6 R7 R8 R10", "lane0", k, sym_lane0, e0);
            chk("R3 R7 R8 R10", "lane1", k, sym_lane1, e1);
            chk("R3 R7 R8 R1", "lane2", k, sym_lane2, e2);
            chk("R8", "pix_ready", k, {19'd0, pix_ready}, {19'd0, rdy_exp});
            chk("R9", "line_req", k, {19'd0, line_req}, {19'd0, req_exp});
            chk("R11", "underrun_err", k, {19'd0, underrun_err}, {19'd0, err_exp});
            if (rdy_exp && !valid_k) err_exp = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        h_front = 12'd2; h_sync = 12'd3; h_back = 12'd1; h_active = 12'd4;
        v_front = 12'd1; v_sync = 12'd2; v_back = 12'd1; v_active = 12'd2;
        h_pol = 1'b1; v_pol = 1'b1; pix_none = 1'b0; pix_valid = 1'b0;
        pix_lane0 = '0; pix_lane1 = '0; pix_lane2 = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12", "lane0 in reset", 0, sym_lane0, 20'hD5354);
        chk("R12", "pix_ready in reset", 0, {19'd0, pix_ready}, 20'd0);
        chk("R12", "line_req in reset", 0, {19'd0, line_req}, 20'd0);
        chk("R12", "underrun_err in reset", 0, {19'd0, underrun_err}, 20'd0);
        rst_n = 1'b1;
        #1;
        chk("R12", "lane0 after reset", 0, sym_lane0, 20'hD5354);
        chk("R1 R12", "lane1 after reset", 0, sym_lane1, 20'hD5354);
    endtask

    task automatic test_negative_sync_pixels();
        run_case(2, 3, 1, 4, 1, 2, 1, 2, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    endtask

    task automatic test_positive_sync_pixels();
        run_case(2, 3, 1, 4, 1, 2, 1, 2, 1'b1, 1'b1, 1'b0, 1'b0, 2);
    endtask

    task automatic test_no_pixel_fill();
        run_case(3, 2, 2, 3, 2, 1, 1, 3, 1'b1, 1'b0, 1'b1, 1'b0, 2);
    endtask

    task automatic test_underrun();
        run_case(2, 3, 1, 4, 1, 2, 1, 2, 1'b0, 1'b1, 1'b0, 1'b1, 2);
    endtask

    task automatic test_zero_regions();
        run_case(2, 3, 0, 4, 1, 2, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0, 2);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_negative_sync_pixels();
        test_positive_sync_pixels();
        test_no_pixel_fill();
        test_underrun();
        test_zero_regions();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule